// File: doc/BRIEF.md
# Three-format converter result serial port

This block sends a 16-bit conversion result, held in an output register, out over a single serial data pin. The converter side writes each new result with a one-cycle load strobe. A static two-bit format input picks how the word leaves the block. The first format is a byte-framed asynchronous stream paced by an external serial clock. The second is a plain synchronous stream paced by an external serial clock. The third is a synchronous stream for which the block drives the serial clock itself, at a quarter of the master clock.

A host starts a transfer by pulling chip select low while the active-low ready flag shows a valid word. The ready flag goes high once the word has been sent, and it also goes high for a fixed four-cycle window each time a new word is loaded. A load that arrives during a transfer abandons that transfer. A new transfer then needs chip select to go high and come back low.

The controller has three states. `ST_IDLE` waits for a start. `ST_SHIFT` moves bits out. `ST_HOLD` waits for chip select to go high after a word has been used up or a transfer has been abandoned. The transitions are as follows:
- start: `ST_IDLE` to `ST_SHIFT`.
- finish: `ST_SHIFT` to `ST_HOLD`, on the last bit's advance.
- preempt: `ST_SHIFT` to `ST_HOLD`, on a load while chip select is low.
- deselect: `ST_SHIFT` or `ST_HOLD` to `ST_IDLE`, when chip select is high.

Top module: `adc_serial_port`

## Requirements
- R1: The format input `mode_sel` selects the format: 2'b00 is asynchronous framed, 2'b01 and 2'b11 are synchronous with an external clock, and 2'b10 is self-clocked. `sclk_oe` is 1 only for 2'b10, and the serial clock is an input in every other format.
- R2: A transfer starts at the first clock edge at which chip select is low, a word is valid, and the four-cycle load window has ended. The first bit appears on `sdata` one cycle after that edge, which is one cycle after `rdy_n` falls.
- R3: In the external-clock synchronous formats, the word is sent as 16 bits, most significant first. The block moves to the next bit one master cycle after it samples a falling edge on `sclk_in`.
- R4: In the asynchronous format, the bits leave in this order: a 0 start bit, the high byte least significant bit first, two 1 stop bits, a 0 start bit, the low byte least significant bit first, and two 1 stop bits. That makes 22 bits, and each one advances on a falling edge of `sclk_in` as in R3.
- R5: In the self-clocked format, each bit lasts four master cycles. `sclk_out` is low for the first three of those cycles and high for the fourth. The data moves to the next bit on the same edge at which `sclk_out` falls, so `sdata` is stable while `sclk_out` is high.
- R6: After the last bit's advance, `rdy_n` reads 1 and `sdata` reads 1.
- R7: A load drives `rdy_n` high for exactly four cycles, starting the cycle after the strobe. After that `rdy_n` reads 0.
- R8: A load during a transfer sets `sdata` to 1 from the next cycle. No bits go out again until chip select has gone high and then low, and the bits that follow are the new word.
- R9: One cycle after chip select goes high, `sdata` is 1 and `sclk_out` is 0. Raising chip select part-way through a word leaves the word valid, and the next chip-select low sends the word again from its first bit.
- R10: A synchronous active-high reset leaves `sdata` at 1, `rdy_n` at 1 and `sclk_out` at 0. No word is valid after reset until the next load.
- R11: Serial clock edges that arrive while chip select is high do not change `sdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Static format select |
| load_stb | input | 1 | One-cycle strobe that loads a new result |
| load_word | input | 16 | Result word that goes with the strobe |
| cs_n | input | 1 | Active-low chip select |
| sclk_in | input | 1 | External serial clock, sampled by the master clock |
| sclk_out | output | 1 | Serial clock driven by the block in the self-clocked format |
| sclk_oe | output | 1 | High when the block drives the serial clock |
| sdata | output | 1 | Serial data, idle high |
| rdy_n | output | 1 | Active-low ready flag |

## Verification
A controller stuck in the wrong state shows up at the ports within one master cycle. If it leaves `ST_SHIFT` too early, `sdata` returns to 1 in the middle of a frame. If it stays in `ST_SHIFT` after the load window, bits keep flowing when they should stop. A wrong bit counter or frame build gives a wrong captured bit in the same transfer, and a divider that is out of phase moves the single high cycle of `sclk_out` or changes `sdata` while the clock is high. A wrong load-window count moves the falling edge of `rdy_n` by at least one cycle, and the four-cycle window checks catch that.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
    typedef enum logic [1:0] {
        FMT_ASYNC   = 2'b00,
        FMT_EXT     = 2'b01,
        FMT_SELF    = 2'b10,
        FMT_EXT_ALT = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01,
        ST_HOLD  = 2'b10
    } tx_state_e;
endpackage

// File: rtl/adc_sp_blank.sv
module adc_sp_blank #(
    parameter int BLANK_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(BLANK_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(BLANK_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/adc_sp_phase.sv
module adc_sp_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (phase == PW'(DIV - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = run && (phase == PW'(DIV - 1));
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              advance,
    input  logic              framed,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out,
    output logic              last
);
    localparam int BYTES   = WORD_W / 8;
    localparam int FRAME_W = BYTES * 11;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] fa;
    logic [FRAME_W-1:0] fs;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   left;

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        assign fa[k*11]          = 1'b0;
        assign fa[k*11+1 +: 8]   = word[WORD_W-1-8*k -: 8];
        assign fa[k*11+9 +: 2]   = 2'b11;
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_plain
        assign fs[i] = word[WORD_W-1-i];
    end

    if (FRAME_W > WORD_W) begin : g_pad
        assign fs[FRAME_W-1:WORD_W] = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
        end else if (start) begin
            sh   <= framed ? fa : fs;
            left <= framed ? CNT_W'(FRAME_W - 1) : CNT_W'(WORD_W - 1);
        end else if (advance) begin
            sh <= {1'b1, sh[FRAME_W-1:1]};
            if (left != '0) begin
                left <= left - 1'b1;
            end
        end
    end

    assign bit_out = sh[0];
    assign last    = (left == '0);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int BLANK_CYC = 4,
    parameter int DIV       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              load_stb,
    input  logic [WORD_W-1:0] load_word,
    input  logic              cs_n,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdata,
    output logic              rdy_n
);
    fmt_e      fmt;
    tx_state_e state, state_nx;
    logic [WORD_W-1:0] word_q;
    logic valid;
    logic sclk_q;
    logic sclk_fall;
    logic blank_busy;
    logic tick;
    logic self_mode;
    logic framed;
    logic start;
    logic advance;
    logic bit_out;
    logic last;

    assign fmt       = fmt_e'(mode_sel);
    assign self_mode = (fmt == FMT_SELF);
    assign framed    = (fmt == FMT_ASYNC);
    assign sclk_fall = sclk_q && !sclk_in;

    assign start   = (state == ST_IDLE) && !cs_n && valid && !blank_busy && !load_stb;
    assign advance = (state == ST_SHIFT) && !cs_n && !load_stb &&
                     (self_mode ? tick : sclk_fall);

    adc_sp_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk  (clk),
        .rst  (rst),
        .load (load_stb),
        .busy (blank_busy)
    );

    adc_sp_phase #(.DIV(DIV)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .run  ((state == ST_SHIFT) && self_mode),
        .tick (tick)
    );

    adc_sp_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .advance (advance),
        .framed  (framed),
        .word    (word_q),
        .bit_out (bit_out),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            valid  <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_in;
            if (load_stb) begin
                word_q <= load_word;
                valid  <= 1'b1;
            end else if (advance && last) begin
                valid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_n)                 state_nx = ST_IDLE;
                else if (load_stb)        state_nx = ST_HOLD;
                else if (advance && last) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_n) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        sdata    = (state == ST_SHIFT) ? bit_out : 1'b1;
        sclk_out = tick;
        sclk_oe  = self_mode;
        rdy_n    = !valid || blank_busy;
    end
endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker (
    input logic clk,
    input logic rst,
    input logic load_stb,
    input logic cs_n,
    input logic sclk_out,
    input logic sdata,
    input logic rdy_n
);
    // R7
    load_blank_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> rdy_n);

    // R7
    blank_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n) |-> $past(rdy_n, 4));

    // R5
    sclk_single_high_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_out |=> !sclk_out);

    // R5
    data_steady_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_out |-> $stable(sdata));

    // R9
    deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (sdata && !sclk_out));
endmodule

bind adc_serial_port adc_sp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_stb (load_stb),
    .cs_n     (cs_n),
    .sclk_out (sclk_out),
    .sdata    (sdata),
    .rdy_n    (rdy_n)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b01;
    logic        load_stb = 1'b0;
    logic [15:0] load_word = '0;
    logic        cs_n = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sclk_out, sclk_oe, sdata, rdy_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_serial_port uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .load_stb(load_stb),
        .load_word(load_word), .cs_n(cs_n), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata(sdata), .rdy_n(rdy_n)
    );

    // {mode, word}
    localparam logic [17:0] VEC [6] = '{
        {2'b01, 16'hA5C3}, {2'b00, 16'h1234}, {2'b10, 16'hF00F},
        {2'b11, 16'h8001}, {2'b00, 16'hFFFE}, {2'b10, 16'h0001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] w);
        load_word = w;
        load_stb  = 1'b1;
        nx();
        load_stb  = 1'b0;
    endtask

    task automatic pulse();
        sclk_in = 1'b1;
        nx();
        sclk_in = 1'b0;
        nx();
    endtask

    function automatic logic [21:0] expect_frame(input logic [1:0] m, input logic [15:0] w);
        logic [21:0] f;
        if (m == 2'b00) begin
            f = {2'b11, w[7:0], 1'b0, 2'b11, w[15:8], 1'b0};
        end else begin
            f = '1;
            for (int i = 0; i < 16; i++) f[i] = w[15-i];
        end
        return f;
    endfunction

    // Called at the negedge after cs_n was lowered and the first bit is up.
    task automatic capture(input logic [1:0] m, output logic [21:0] got, output int sclk_err);
        int nb;
        got = '1;
        sclk_err = 0;
        nb = (m == 2'b00) ? 22 : 16;
        if (m == 2'b10) begin
            for (int b = 0; b < nb; b++) begin
                for (int p = 0; p < 4; p++) begin
                    if (p == 0) got[b] = sdata;
                    if (sclk_out !== (p == 3)) sclk_err++;
                    nx();
                end
            end
        end else begin
            got[0] = sdata;
            for (int b = 1; b < nb; b++) begin
                pulse();
                got[b] = sdata;
            end
            pulse();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [21:0] got;
        logic [21:0] exp;
        int serr;

        repeat (3) nx();
        rst = 1'b0;
        // R10: reset state
        chk("R10 sdata", sdata, 1);
        chk("R10 rdy_n", rdy_n, 1);
        chk("R10 sclk_out", sclk_out, 0);
        cs_n = 1'b0;
        repeat (6) nx();
        chk("R10 no word after reset", {rdy_n, sdata}, 2'b11);
        cs_n = 1'b1;
        nx();

        // table walk: R1, R3, R4, R5, R6
        foreach (VEC[v]) begin
            mode_sel = VEC[v][17:16];
            do_load(VEC[v][15:0]);
            repeat (5) nx();
            chk("R7 ready after window", rdy_n, 0);
            chk("R1 clock direction", sclk_oe, (VEC[v][17:16] == 2'b10));
            cs_n = 1'b0;
            nx();
            capture(VEC[v][17:16], got, serr);
            exp = expect_frame(VEC[v][17:16], VEC[v][15:0]);
            if (VEC[v][17:16] == 2'b00)      chk("R4 async frame", got, exp);
            else if (VEC[v][17:16] == 2'b10) chk("R5 self-clocked word", got[15:0], exp[15:0]);
            else                             chk("R3 sync word", got[15:0], exp[15:0]);
            if (VEC[v][17:16] == 2'b10) chk("R5 sclk pattern errors", serr, 0);
            chk("R6 done flag", rdy_n, 1);
            chk("R6 done data", sdata, 1);
            cs_n = 1'b1;
            nx();
        end

        // R7: exact four-cycle window
        mode_sel = 2'b01;
        do_load(16'h3C3C);
        for (int k = 1; k <= 5; k++) begin
            chk($sformatf("R7 window cycle %0d", k), rdy_n, (k <= 4));
            if (k < 5) nx();
        end

        // R2: cs low during window, first bit one cycle after rdy_n falls
        do_load(16'h7F00);
        cs_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            chk("R2 no start in window", sdata, 1);
            nx();
        end
        chk("R2 ready low k5", rdy_n, 0);
        chk("R2 still idle k5", sdata, 1);
        nx();
        chk("R2 first bit k6", sdata, 0);
        cs_n = 1'b1;
        nx();

        // R8: load during transfer preempts
        mode_sel = 2'b01;
        do_load(16'h0F0F);
        repeat (5) nx();
        cs_n = 1'b0;
        nx();
        for (int b = 0; b < 5; b++) pulse();
        do_load(16'h6A95);
        chk("R8 data idle after preempt", sdata, 1);
        chk("R8 window after preempt", rdy_n, 1);
        repeat (6) nx();
        chk("R8 ready again", rdy_n, 0);
        pulse();
        chk("R8 no restart while cs low", sdata, 1);
        cs_n = 1'b1;
        nx();
        cs_n = 1'b0;
        nx();
        capture(2'b01, got, serr);
        exp = expect_frame(2'b01, 16'h6A95);
        chk("R8 new word sent", got[15:0], exp[15:0]);
        cs_n = 1'b1;
        nx();

        // R9 and R11: deselect mid-word, clock edges ignored
        do_load(16'h4E21);
        repeat (5) nx();
        cs_n = 1'b0;
        nx();
        for (int b = 0; b < 3; b++) pulse();
        cs_n = 1'b1;
        nx();
        chk("R9 idle after deselect", sdata, 1);
        chk("R9 word still valid", rdy_n, 0);
        for (int b = 0; b < 4; b++) pulse();
        chk("R11 edges ignored", sdata, 1);
        cs_n = 1'b0;
        nx();
        capture(2'b01, got, serr);
        exp = expect_frame(2'b01, 16'h4E21);
        chk("R9 restart from first bit", got[15:0], exp[15:0]);
        cs_n = 1'b1;
        nx();

        // R9: self-clocked deselect stops the clock
        mode_sel = 2'b10;
        do_load(16'h9999);
        repeat (5) nx();
        cs_n = 1'b0;
        repeat (7) nx();
        cs_n = 1'b1;
        nx();
        serr = 0;
        for (int k = 0; k < 8; k++) begin
            if (sclk_out !== 1'b0 || sdata !== 1'b1) serr++;
            nx();
        end
        chk("R9 self clock held low", serr, 0);

        // R10: reset mid-transfer
        mode_sel = 2'b01;
        do_load(16'h0001);
        repeat (5) nx();
        cs_n = 1'b0;
        nx();
        pulse();
        rst = 1'b1;
        nx();
        rst = 1'b0;
        chk("R10 reset mid-word data", sdata, 1);
        chk("R10 reset mid-word flag", rdy_n, 1);
        repeat (6) nx();
        chk("R10 nothing valid after reset", {rdy_n, sdata}, 2'b11);
        cs_n = 1'b1;
        nx();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule